// File: doc/BRIEF.md
# Instruction Breakpoint Matcher

This block sits beside the fetch stage of a pipeline and decides, for every fetch address, which instruction word goes on to decode. It keeps a small set of breakpoint addresses that a debugger manages with two commands: one inserts an address into the set and one deletes it. Slots are never addressed directly. When the current fetch address equals any address in the set, the block delivers the breakpoint trap opcode in place of the word read from memory.

A second mechanism holds a single address and a replacement instruction. When the fetch address equals that address, the programmed replacement is delivered instead of memory data. This lets a debugger run the original instruction that sits under a software breakpoint without rewriting memory. If both mechanisms match, the trap opcode wins. The fetch path is purely combinational. Command writes are registered and change the block's behaviour from the clock edge that captures them.

Top module: `bkpt_matcher`

## Requirements
- R1: After reset the breakpoint set is empty, so no fetch address produces a breakpoint hit. The override address and the override instruction are both zero, so a fetch at address 0 delivers 0 with `ovr_hit` high.
- R2: A write with `wr_en` high is decoded by `wr_sel` as follows: 0 inserts, 1 deletes, 2 loads the override address, 3 loads the override instruction (from the low 32 bits of `wr_data`). The write takes effect at the rising edge that samples it. Nothing changes in a cycle with `wr_en` low.
- R3: When `fetch_pc` equals a stored address, in the same cycle `instr_out` is 0x00100073 and `bkpt_hit` is 1.
- R4: Inserting an address that is already stored leaves the set unchanged and uses no extra slot.
- R5: The set holds 8 addresses. An insert while all 8 slots are occupied is ignored, and the rejected address produces no hit.
- R6: A delete removes the matching address, so it no longer hits. Deleting an address that is not stored has no effect. A freed slot can take a later insert.
- R7: When `fetch_pc` equals the override address and no breakpoint matches, `instr_out` is the override instruction and `ovr_hit` is 1.
- R8: While the override address is all ones, the override never matches, including at fetch address all ones.
- R9: When a fetch address matches both the set and the override, `instr_out` is 0x00100073, `bkpt_hit` is 1 and `ovr_hit` is 0.
- R10: With no match of either kind, `instr_out` equals `mem_instr` and both hit flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Command write strobe |
| wr_sel | input | 2 | Command select: 0 insert, 1 delete, 2 override address, 3 override instruction |
| wr_data | input | 64 | Command operand (address, or instruction in the low 32 bits) |
| fetch_pc | input | 64 | Current fetch address |
| mem_instr | input | 32 | Instruction word read from memory |
| instr_out | output | 32 | Instruction delivered to decode |
| bkpt_hit | output | 1 | Fetch address matched a stored breakpoint |
| ovr_hit | output | 1 | Override instruction delivered |

## Verification
A corrupted slot valid bit or stored address shows up as a missing or spurious trap opcode the first time that address is fetched. Because the compare is combinational, the fault is visible in the same cycle. A slot leak from a duplicate insert, or a failure to free a slot on delete, stays hidden until the set fills. The bench therefore fills the set exactly and probes every member, plus the first address that should be refused. A wrong override register appears at once as the wrong replacement word, or as a missing replacement, at its own address.

// File: rtl/bkm_pkg.sv
package bkm_pkg;
    localparam logic [31:0] TRAP_OPCODE = 32'h0010_0073;

    typedef enum logic [1:0] {
        CMD_INSERT   = 2'd0,
        CMD_DELETE   = 2'd1,
        CMD_OVR_ADDR = 2'd2,
        CMD_OVR_INS  = 2'd3
    } cmd_e;
endpackage

// File: rtl/bkm_cam.sv
module bkm_cam #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0]             key,
    input  logic [DEPTH-1:0]              slot_vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  slot_adr,
    output logic [DEPTH-1:0]              hit_vec
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = slot_vld[g] && (slot_adr[g] == key);
    end
endmodule

// File: rtl/bkm_set.sv
module bkm_set #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ins_en,
    input  logic                          del_en,
    input  logic [ADDR_W-1:0]             cmd_addr,
    input  logic [DEPTH-1:0]              cmd_hit,
    output logic [DEPTH-1:0]              slot_vld,
    output logic [DEPTH-1:0][ADDR_W-1:0]  slot_adr
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][ADDR_W-1:0] adr;
    } set_t;

    set_t             st_d, st_q;
    logic [IDX_W-1:0] free_idx;
    logic             have_free;
    logic             present;

    always_comb begin
        free_idx  = '0;
        have_free = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!st_q.vld[i]) begin
                free_idx  = IDX_W'(i);
                have_free = 1'b1;
            end
        end
        present = |cmd_hit;

        st_d = st_q;
        if (ins_en && !present && have_free) begin
            st_d.vld[free_idx] = 1'b1;
            st_d.adr[free_idx] = cmd_addr;
        end
        if (del_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cmd_hit[i]) begin
                    st_d.vld[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_vld = st_q.vld;
    assign slot_adr = st_q.adr;
endmodule

// File: rtl/bkm_ovr.sv
module bkm_ovr #(
    parameter int ADDR_W  = 64,
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adr_we,
    input  logic               ins_we,
    input  logic [ADDR_W-1:0]  wdata_adr,
    input  logic [INSTR_W-1:0] wdata_ins,
    input  logic [ADDR_W-1:0]  fetch_pc,
    output logic               ovr_match,
    output logic [INSTR_W-1:0] ovr_ins
);
    typedef struct packed {
        logic [ADDR_W-1:0]  adr;
        logic [INSTR_W-1:0] ins;
    } ovr_t;

    ovr_t ov_d, ov_q;

    always_comb begin
        ov_d = ov_q;
        if (adr_we) begin
            ov_d.adr = wdata_adr;
        end
        if (ins_we) begin
            ov_d.ins = wdata_ins;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov_q <= '0;
        end else begin
            ov_q <= ov_d;
        end
    end

    assign ovr_match = !(&ov_q.adr) && (fetch_pc == ov_q.adr);
    assign ovr_ins   = ov_q.ins;
endmodule

// File: rtl/bkm_mux.sv
module bkm_mux #(
    parameter int INSTR_W = 32
) (
    input  logic               bkpt_any,
    input  logic               ovr_match,
    input  logic [INSTR_W-1:0] ovr_ins,
    input  logic [INSTR_W-1:0] mem_instr,
    output logic [INSTR_W-1:0] instr_out,
    output logic               bkpt_hit,
    output logic               ovr_hit
);
    import bkm_pkg::*;

    always_comb begin
        bkpt_hit  = 1'b0;
        ovr_hit   = 1'b0;
        instr_out = mem_instr;
        if (bkpt_any) begin
            bkpt_hit  = 1'b1;
            instr_out = INSTR_W'(TRAP_OPCODE);
        end else if (ovr_match) begin
            ovr_hit   = 1'b1;
            instr_out = ovr_ins;
        end
    end
endmodule

// File: rtl/bkpt_matcher.sv
module bkpt_matcher #(
    parameter int DEPTH   = 8,
    parameter int ADDR_W  = 64,
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [ADDR_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  fetch_pc,
    input  logic [INSTR_W-1:0] mem_instr,
    output logic [INSTR_W-1:0] instr_out,
    output logic               bkpt_hit,
    output logic               ovr_hit
);
    import bkm_pkg::*;

    logic [DEPTH-1:0]             slot_valid;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_adr;
    logic [DEPTH-1:0]             cmd_hit;
    logic [DEPTH-1:0]             pc_hit;
    logic                         ovr_match;
    logic [INSTR_W-1:0]           ovr_ins;
    logic                         ins_en, del_en, oadr_we, oins_we;
    logic                         unused_wr_hi;

    assign ins_en  = wr_en && (wr_sel == CMD_INSERT);
    assign del_en  = wr_en && (wr_sel == CMD_DELETE);
    assign oadr_we = wr_en && (wr_sel == CMD_OVR_ADDR);
    assign oins_we = wr_en && (wr_sel == CMD_OVR_INS);

    if (ADDR_W > INSTR_W) begin : g_hi
        assign unused_wr_hi = ^wr_data[ADDR_W-1:INSTR_W];
    end else begin : g_nohi
        assign unused_wr_hi = 1'b0;
    end

    bkm_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cmd_cam (
        .key      (wr_data),
        .slot_vld (slot_valid),
        .slot_adr (slot_adr),
        .hit_vec  (cmd_hit)
    );

    bkm_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_pc_cam (
        .key      (fetch_pc),
        .slot_vld (slot_valid),
        .slot_adr (slot_adr),
        .hit_vec  (pc_hit)
    );

    bkm_set #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_set (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (ins_en),
        .del_en   (del_en),
        .cmd_addr (wr_data),
        .cmd_hit  (cmd_hit),
        .slot_vld (slot_valid),
        .slot_adr (slot_adr)
    );

    bkm_ovr #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_ovr (
        .clk       (clk),
        .rst_n     (rst_n),
        .adr_we    (oadr_we),
        .ins_we    (oins_we),
        .wdata_adr (wr_data),
        .wdata_ins (wr_data[INSTR_W-1:0]),
        .fetch_pc  (fetch_pc),
        .ovr_match (ovr_match),
        .ovr_ins   (ovr_ins)
    );

    bkm_mux #(.INSTR_W(INSTR_W)) u_mux (
        .bkpt_any  (|pc_hit),
        .ovr_match (ovr_match),
        .ovr_ins   (ovr_ins),
        .mem_instr (mem_instr),
        .instr_out (instr_out),
        .bkpt_hit  (bkpt_hit),
        .ovr_hit   (ovr_hit)
    );
endmodule

// File: rtl/bkm_checker.sv
module bkm_checker #(
    parameter int DEPTH   = 8,
    parameter int ADDR_W  = 64,
    parameter int INSTR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         wr_sel,
    input logic [ADDR_W-1:0]  fetch_pc,
    input logic [INSTR_W-1:0] mem_instr,
    input logic [INSTR_W-1:0] instr_out,
    input logic               bkpt_hit,
    input logic               ovr_hit,
    input logic [DEPTH-1:0]   slot_valid
);
    import bkm_pkg::*;

    // R3
    trap_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_hit |-> (instr_out == INSTR_W'(TRAP_OPCODE)));

    // R9
    single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bkpt_hit && ovr_hit));

    // R10
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bkpt_hit && !ovr_hit) |-> (instr_out == mem_instr));

    // R8
    ovr_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_hit |-> (fetch_pc != '1));

    // R5
    full_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == CMD_INSERT && (&slot_valid)) |=> $stable(slot_valid));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(slot_valid));

    // R6
    delete_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == CMD_DELETE) |=>
        ($countones(slot_valid) <= $countones($past(slot_valid))));
endmodule

bind bkpt_matcher bkm_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .fetch_pc   (fetch_pc),
    .mem_instr  (mem_instr),
    .instr_out  (instr_out),
    .bkpt_hit   (bkpt_hit),
    .ovr_hit    (ovr_hit),
    .slot_valid (slot_valid)
);

// File: tb/sim_bkpt_matcher.sv
`timescale 1ns/1ps
module sim_bkpt_matcher;
    localparam logic [31:0] TRAP = 32'h0010_0073;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [63:0] wr_data = '0;
    logic [63:0] fetch_pc = 64'h10;
    logic [31:0] mem_instr = 32'h1111_1111;
    logic [31:0] instr_out;
    logic        bkpt_hit, ovr_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bkpt_matcher u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .fetch_pc(fetch_pc), .mem_instr(mem_instr),
        .instr_out(instr_out), .bkpt_hit(bkpt_hit), .ovr_hit(ovr_hit)
    );

    task automatic cmd(input logic [1:0] sel, input logic [63:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(input logic [63:0] pc, input logic [31:0] mem,
                         input logic [31:0] exp_ins, input bit exp_b,
                         input bit exp_o, input string req);
        fetch_pc = pc; mem_instr = mem;
        #1;
        checks++;
        if (instr_out !== exp_ins || bkpt_hit !== exp_b || ovr_hit !== exp_o) begin
            errors++;
            $display("FAIL %s pc=%h actual ins=%h b=%0d o=%0d expected ins=%h b=%0d o=%0d",
                     req, pc, instr_out, bkpt_hit, ovr_hit, exp_ins, exp_b, exp_o);
        end
    endtask

    task automatic t_reset;
        probe(64'h1000, 32'hA5A5_0001, 32'hA5A5_0001, 0, 0, "R1");
        probe(64'h0,    32'hA5A5_0002, 32'h0,         0, 1, "R1");
    endtask

    task automatic t_insert;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 64'h1000;
        probe(64'h1000, 32'h2222_0000, 32'h2222_0000, 0, 0, "R2");
        @(negedge clk);
        wr_en = 1'b0;
        probe(64'h1000, 32'h2222_0000, TRAP, 1, 0, "R3");
        probe(64'h1004, 32'h2222_0004, 32'h2222_0004, 0, 0, "R10");
        probe(64'h1004, 32'h3333_0004, 32'h3333_0004, 0, 0, "R10");
    endtask

    task automatic t_duplicate;
        cmd(2'd0, 64'h1000);
        for (int i = 0; i < 7; i++) cmd(2'd0, 64'h2000 + 64'(i) * 4);
        probe(64'h1000, 32'h5, TRAP, 1, 0, "R4");
        for (int i = 0; i < 7; i++) probe(64'h2000 + 64'(i) * 4, 32'h5, TRAP, 1, 0, "R4");
    endtask

    task automatic t_full;
        cmd(2'd0, 64'h3000);
        probe(64'h3000, 32'h77, 32'h77, 0, 0, "R5");
        probe(64'h1000, 32'h77, TRAP, 1, 0, "R5");
    endtask

    task automatic t_delete;
        cmd(2'd1, 64'h9999);
        probe(64'h1000, 32'h8, TRAP, 1, 0, "R6");
        for (int i = 0; i < 7; i++) probe(64'h2000 + 64'(i) * 4, 32'h8, TRAP, 1, 0, "R6");
        cmd(2'd1, 64'h2000);
        probe(64'h2000, 32'h8, 32'h8, 0, 0, "R6");
        probe(64'h2004, 32'h8, TRAP, 1, 0, "R6");
        cmd(2'd0, 64'h3000);
        probe(64'h3000, 32'h8, TRAP, 1, 0, "R6");
    endtask

    task automatic t_override;
        cmd(2'd2, 64'h4000);
        cmd(2'd3, 64'hFFFF_FFFF_DEAD_BEEF);
        probe(64'h4000, 32'h9, 32'hDEAD_BEEF, 0, 1, "R7");
        probe(64'h0,    32'h9, 32'h9,         0, 0, "R7");
    endtask

    task automatic t_priority;
        cmd(2'd1, 64'h2004);
        cmd(2'd0, 64'h4000);
        probe(64'h4000, 32'hA, TRAP, 1, 0, "R9");
        cmd(2'd1, 64'h4000);
        probe(64'h4000, 32'hA, 32'hDEAD_BEEF, 0, 1, "R9");
    endtask

    task automatic t_disable;
        cmd(2'd2, '1);
        probe('1,       32'hB, 32'hB, 0, 0, "R8");
        probe(64'h4000, 32'hB, 32'hB, 0, 0, "R8");
    endtask

    initial begin
        #23;
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        t_insert;
        t_duplicate;
        t_full;
        t_delete;
        t_override;
        t_priority;
        t_disable;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule